// File: doc/BRIEF.md
# Accumulator with Adder and Logic Stage

This block holds a 16-bit accumulator and a one-bit extend flag. Each cycle it either clears the accumulator, increments it, loads it from a per-bit adder and logic stage, or keeps it as it is. The adder and logic stage can produce seven results from the accumulator, a 16-bit data operand and an 8-bit input byte. These are a ripple-carry sum, a bitwise AND, a copy of the data operand, the input byte placed in the low half, the bitwise inverse, and a rotate one place right or left through the extend flag. A one-hot enable vector from an external decoder picks one of the seven results.

Clear and increment are controlled separately. A register-reference strobe is qualified by two instruction bits, and these two paths take priority over any load. The extend flag takes the carry out of the sum and the bit shifted out by a rotate. All other actions leave it unchanged.

Top module: `acc_alu_unit`

## Requirements
- R1: While `rst_n` is low, the next clock edge sets the accumulator and the extend flag to zero.
- R2: With `op_en` = bit 1 only, the accumulator becomes (AC + DR) mod 2^16 and E becomes the carry out of bit 15.
- R3: With `op_en` = bit 0 only, the accumulator becomes AC AND DR.
- R4: With `op_en` = bit 2 only, the accumulator becomes DR.
- R5: With `op_en` = bit 3 only, AC[7:0] takes the input byte and AC[15:8] becomes zero.
- R6: With `op_en` = bit 4 only, the accumulator becomes its bitwise inverse.
- R7: With `op_en` = bit 5 only, the accumulator becomes {E, AC[15:1]} and E becomes the old AC[0].
- R8: With `op_en` = bit 6 only, the accumulator becomes {AC[14:0], E} and E becomes the old AC[15].
- R9: When `ref_exec` and `ir_b5` are high and `ir_b11` is low, the accumulator becomes (AC + 1) mod 2^16.
- R10: When `ref_exec` and `ir_b11` are high, the accumulator becomes zero, whatever `ir_b5` and `op_en` are.
- R11: Increment takes priority over any load enabled in the same cycle.
- R12: If no `op_en` bit is set and neither clear nor increment is qualified, the accumulator and E hold their values.
- R13: E stays unchanged by AND, both transfers, complement, increment and clear.
- R14: At most one `op_en` bit is set in any cycle. The environment must guarantee this, and the checker flags a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_en | input | 7 | One-hot operation enables: 0 AND, 1 ADD, 2 DR copy, 3 byte input, 4 invert, 5 rotate right, 6 rotate left |
| dr_in | input | 16 | Data-register operand |
| inp_in | input | 8 | Input-register byte |
| ref_exec | input | 1 | Register-reference execute strobe |
| ir_b5 | input | 1 | Instruction bit selecting increment |
| ir_b11 | input | 1 | Instruction bit selecting clear |
| ac_out | output | 16 | Accumulator contents |
| e_out | output | 1 | Extend/carry flag |

## Verification
The hardest cases are the collisions, where a load enable and a qualified clear or increment arrive in the same cycle. The extend flag has to stay intact through them. The bench loads the accumulator through the DR-copy operation before each collision, then drives every operation together with all eight combinations of the strobe and the two instruction bits. The carry and rotate paths depend on what E holds, so sums that overflow and rotates are interleaved. This makes E take both values in front of every rotate, and the model tracks E from the ports alone.

// File: rtl/acc_alu_pkg.sv
// Package: shared constants and types for the accumulator block.
// Assumes op_en bit positions below match the external decoder.
package acc_alu_pkg;
    localparam int NUM_OPS   = 7;
    localparam int OP_AND    = 0;
    localparam int OP_ADD    = 1;
    localparam int OP_CPY_DR = 2;
    localparam int OP_CPY_IN = 3;
    localparam int OP_INV    = 4;
    localparam int OP_ROR    = 5;
    localparam int OP_ROL    = 6;

    // Action chosen for the accumulator register in one cycle.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_INCR  = 2'd2,
        ACT_CLEAR = 2'd3
    } acc_act_e;
endpackage

// File: rtl/acc_ripple_adder.sv
// Ripple-carry adder built from one full adder per bit.
// Assumes: carry in is zero; carry out of the top bit is exported.
module acc_ripple_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    logic [WIDTH:0] chain;

    assign chain[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_fa
            // One full-adder cell: sum and carry to the next bit.
            assign sum_out[gi]  = a_in[gi] ^ b_in[gi] ^ chain[gi];
            assign chain[gi+1]  = (a_in[gi] & b_in[gi]) | (chain[gi] & (a_in[gi] ^ b_in[gi]));
        end
    endgenerate

    assign carry_out = chain[WIDTH];
endmodule

// File: rtl/acc_logic_stage.sv
// Per-bit result selection: each bit ORs seven enable-gated terms.
// Assumes op_en is one-hot or zero; if several bits are set the terms
// are ORed together. Also computes the next extend-flag value and the
// load request.
module acc_logic_stage
    import acc_alu_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int IN_WIDTH = 8
) (
    input  logic [NUM_OPS-1:0]  op_en,
    input  logic [WIDTH-1:0]    ac,
    input  logic [WIDTH-1:0]    dr,
    input  logic [IN_WIDTH-1:0] inp,
    input  logic                e_cur,
    input  logic [WIDTH-1:0]    add_sum,
    input  logic                add_cout,
    output logic [WIDTH-1:0]    result,
    output logic                e_next,
    output logic                load_req
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic [NUM_OPS-1:0] terms;
            logic               ror_src;
            logic               rol_src;
            logic               in_src;

            if (gi == WIDTH-1) begin : g_ror_top
                assign ror_src = e_cur;
            end else begin : g_ror_mid
                assign ror_src = ac[gi+1];
            end

            if (gi == 0) begin : g_rol_bot
                assign rol_src = e_cur;
            end else begin : g_rol_mid
                assign rol_src = ac[gi-1];
            end

            if (gi < IN_WIDTH) begin : g_in_low
                assign in_src = inp[gi];
            end else begin : g_in_high
                assign in_src = 1'b0;
            end

            // Gather the candidate value of this bit for every operation.
            always_comb begin
                terms            = '0;
                terms[OP_AND]    = ac[gi] & dr[gi];
                terms[OP_ADD]    = add_sum[gi];
                terms[OP_CPY_DR] = dr[gi];
                terms[OP_CPY_IN] = in_src;
                terms[OP_INV]    = ~ac[gi];
                terms[OP_ROR]    = ror_src;
                terms[OP_ROL]    = rol_src;
            end

            assign result[gi] = |(terms & op_en);
        end
    endgenerate

    // Next extend flag: carry for add, shifted-out bit for rotates.
    always_comb begin
        if (op_en[OP_ADD])      e_next = add_cout;
        else if (op_en[OP_ROR]) e_next = ac[0];
        else if (op_en[OP_ROL]) e_next = ac[WIDTH-1];
        else                    e_next = e_cur;
    end

    assign load_req = |op_en;
endmodule

// File: rtl/acc_ctrl.sv
// Priority control of the accumulator: clear, then increment, then load.
// Assumes ref_exec is the already-decoded register-reference strobe.
module acc_ctrl
    import acc_alu_pkg::*;
(
    input  logic     ref_exec,
    input  logic     ir_b5,
    input  logic     ir_b11,
    input  logic     load_req,
    output acc_act_e action
);
    // Pick the single action for this cycle by fixed priority.
    always_comb begin
        if (ref_exec && ir_b11)     action = ACT_CLEAR;
        else if (ref_exec && ir_b5) action = ACT_INCR;
        else if (load_req)          action = ACT_LOAD;
        else                        action = ACT_HOLD;
    end
endmodule

// File: rtl/acc_alu_unit.sv
// Top: accumulator and extend flag with adder/logic load path and
// separate clear/increment controls. Synchronous active-low reset.
// Assumes op_en is one-hot or zero (checked by the bound checker).
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int IN_WIDTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_OPS-1:0]  op_en,
    input  logic [WIDTH-1:0]    dr_in,
    input  logic [IN_WIDTH-1:0] inp_in,
    input  logic                ref_exec,
    input  logic                ir_b5,
    input  logic                ir_b11,
    output logic [WIDTH-1:0]    ac_out,
    output logic                e_out
);
    logic [WIDTH-1:0] ac_q;
    logic             e_q;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic [WIDTH-1:0] stage_res;
    logic             stage_e;
    logic             load_req;
    acc_act_e         action;
    logic [WIDTH-1:0] ac_d;
    logic             e_d;

    acc_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .a_in      (ac_q),
        .b_in      (dr_in),
        .sum_out   (sum),
        .carry_out (cout)
    );

    acc_logic_stage #(.WIDTH(WIDTH), .IN_WIDTH(IN_WIDTH)) u_stage (
        .op_en    (op_en),
        .ac       (ac_q),
        .dr       (dr_in),
        .inp      (inp_in),
        .e_cur    (e_q),
        .add_sum  (sum),
        .add_cout (cout),
        .result   (stage_res),
        .e_next   (stage_e),
        .load_req (load_req)
    );

    acc_ctrl u_ctrl (
        .ref_exec (ref_exec),
        .ir_b5    (ir_b5),
        .ir_b11   (ir_b11),
        .load_req (load_req),
        .action   (action)
    );

    // Next-state selection for accumulator and extend flag.
    always_comb begin
        ac_d = ac_q;
        e_d  = e_q;
        unique case (action)
            ACT_CLEAR: ac_d = '0;
            ACT_INCR:  ac_d = ac_q + {{(WIDTH-1){1'b0}}, 1'b1};
            ACT_LOAD: begin
                ac_d = stage_res;
                e_d  = stage_e;
            end
            default:   ac_d = ac_q;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q <= '0;
            e_q  <= 1'b0;
        end else begin
            ac_q <= ac_d;
            e_q  <= e_d;
        end
    end

    assign ac_out = ac_q;
    assign e_out  = e_q;
endmodule

// File: rtl/acc_alu_checker.sv
// Checker: port-level temporal properties of acc_alu_unit, bound below.
module acc_alu_checker
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OPS-1:0] op_en,
    input logic [WIDTH-1:0]   dr_in,
    input logic               ref_exec,
    input logic               ir_b5,
    input logic               ir_b11,
    input logic [WIDTH-1:0]   ac_out,
    input logic               e_out
);
    logic no_ref;
    assign no_ref = !(ref_exec && (ir_b5 || ir_b11));

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (ac_out == '0 && e_out == 1'b0)); // R1

    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ref && op_en == 7'b0000010) |=>
        ({e_out, ac_out} == ({1'b0, $past(ac_out)} + {1'b0, $past(dr_in)}))); // R2

    AST_ROR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ref && op_en == 7'b0100000) |=>
        ({ac_out, e_out} == {$past(e_out), $past(ac_out)})); // R7

    AST_INCR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_exec && ir_b5 && !ir_b11) |=>
        (ac_out == $past(ac_out) + {{(WIDTH-1){1'b0}}, 1'b1} && $stable(e_out))); // R11

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_exec && ir_b11) |=> (ac_out == '0 && $stable(e_out))); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ref && op_en == '0) |=> ($stable(ac_out) && $stable(e_out))); // R12

    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ref && (op_en == 7'b0000001 || op_en == 7'b0000100 ||
                    op_en == 7'b0001000 || op_en == 7'b0010000)) |=> $stable(e_out)); // R13

    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_en)); // R14
endmodule

bind acc_alu_unit acc_alu_checker #(.WIDTH(WIDTH)) u_acc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_en    (op_en),
    .dr_in    (dr_in),
    .ref_exec (ref_exec),
    .ir_b5    (ir_b5),
    .ir_b11   (ir_b11),
    .ac_out   (ac_out),
    .e_out    (e_out)
);

// File: tb/test_acc_alu_unit.sv
module test_acc_alu_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  op_en = '0;
    logic [15:0] dr_in = '0;
    logic [7:0]  inp_in = '0;
    logic        ref_exec = 1'b0;
    logic        ir_b5 = 1'b0;
    logic        ir_b11 = 1'b0;
    logic [15:0] ac_out;
    logic        e_out;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [15:0] m_ac = '0;
    logic        m_e = 1'b0;

    acc_alu_unit i_acc_alu_unit (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .dr_in(dr_in), .inp_in(inp_in),
        .ref_exec(ref_exec), .ir_b5(ir_b5), .ir_b11(ir_b11),
        .ac_out(ac_out), .e_out(e_out)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    function automatic logic [15:0] pick(input int k);
        case (k)
            0: pick = 16'h0000;
            1: pick = 16'hFFFF;
            2: pick = 16'h8000;
            3: pick = 16'h0001;
            4: pick = 16'h7FFF;
            default: pick = 16'((k * 40503) ^ (k << 7) ^ (k * 7));
        endcase
    endfunction

    task automatic compare(input string tag);
        n_checks++;
        if (ac_out !== m_ac || e_out !== m_e) begin
            n_errors++;
            $display("FAIL %s: actual ac=%h e=%b expected ac=%h e=%b",
                     tag, ac_out, e_out, m_ac, m_e);
        end
    endtask

    // Called at a falling edge: drive, update model, check at next falling edge.
    task automatic step(input int op, input logic [15:0] dr, input logic [7:0] inp,
                        input logic r, input logic b5, input logic b11, input string tag);
        logic [16:0] wide;
        logic [15:0] nac;
        logic        ne;
        op_en    = (op >= 0) ? 7'(1 << op) : 7'd0;
        dr_in    = dr;
        inp_in   = inp;
        ref_exec = r;
        ir_b5    = b5;
        ir_b11   = b11;
        nac = m_ac;
        ne  = m_e;
        case (op)
            0: nac = m_ac & dr;
            1: begin wide = {1'b0, m_ac} + {1'b0, dr}; nac = wide[15:0]; ne = wide[16]; end
            2: nac = dr;
            3: nac = {8'h00, inp};
            4: nac = ~m_ac;
            5: begin nac = {m_e, m_ac[15:1]}; ne = m_ac[0]; end
            6: begin nac = {m_ac[14:0], m_e}; ne = m_ac[15]; end
            default: ;
        endcase
        if (r && b11) begin nac = 16'h0000; ne = m_e; end
        else if (r && b5) begin nac = m_ac + 16'd1; ne = m_e; end
        m_ac = nac;
        m_e  = ne;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        string otag [7] = '{"R3", "R2", "R4", "R5", "R6", "R7", "R8"};
        @(negedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;

        // Two-operand sweep for every load operation.
        for (int op = 0; op < 7; op++) begin
            for (int i = 0; i < 20; i++) begin
                for (int j = 0; j < 12; j++) begin
                    step(2, pick(i), 8'h00, 1'b0, 1'b0, 1'b0, "R4");
                    step(op, pick(j), 8'(pick(j + 3)), 1'b0, 1'b0, 1'b0, otag[op]);
                end
            end
        end

        // Rotates chained so E carries both values through.
        for (int i = 0; i < 40; i++) begin
            step(2, pick(i), 8'h00, 1'b0, 1'b0, 1'b0, "R4");
            for (int k = 0; k < 17; k++) step(5, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0, "R7");
            for (int k = 0; k < 17; k++) step(6, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0, "R8");
        end

        // Collisions: every operation with every control combination.
        for (int op = -1; op < 7; op++) begin
            for (int c = 0; c < 8; c++) begin
                for (int i = 0; i < 8; i++) begin
                    logic r, b5, b11;
                    string tag;
                    r = c[0]; b5 = c[1]; b11 = c[2];
                    if (r && b11) tag = "R10";
                    else if (r && b5) tag = (op < 0) ? "R9" : "R11";
                    else if (op < 0) tag = "R12";
                    else tag = otag[op];
                    step(1, pick(i + 1), 8'h00, 1'b0, 1'b0, 1'b0, "R2");
                    step(2, pick(i), 8'h00, 1'b0, 1'b0, 1'b0, "R4");
                    step(op, pick(i + 5), 8'(pick(i + 9)), r, b5, b11, tag);
                    step(-1, 16'hA5A5, 8'h5A, 1'b0, 1'b0, 1'b0, "R12");
                end
            end
        end

        // E survival: set E via carry, then non-E operations.
        for (int op = 0; op < 5; op++) begin
            if (op == 1) continue;
            step(2, 16'hFFFF, 8'h00, 1'b0, 1'b0, 1'b0, "R4");
            step(1, 16'h0001, 8'h00, 1'b0, 1'b0, 1'b0, "R2");
            step(op, 16'h1234, 8'hC3, 1'b0, 1'b0, 1'b0, "R13");
            step(-1, 16'h0, 8'h00, 1'b1, 1'b1, 1'b0, "R13");
            step(-1, 16'h0, 8'h00, 1'b1, 1'b0, 1'b1, "R13");
        end

        // Increment wrap at all-ones.
        step(2, 16'hFFFF, 8'h00, 1'b0, 1'b0, 1'b0, "R4");
        step(-1, 16'h0, 8'h00, 1'b1, 1'b1, 1'b0, "R9");

        // Reset from a non-zero state.
        step(2, 16'hBEEF, 8'h00, 1'b0, 1'b0, 1'b0, "R4");
        step(5, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0, "R7");
        rst_n = 1'b0;
        op_en = 7'b0000100;
        dr_in = 16'h1111;
        m_ac = 16'h0000;
        m_e = 1'b0;
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        op_en = '0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule